// File: doc/BRIEF.md
# OLED command and data byte decoder

This block sits behind an I2C target that has already stripped the bus protocol away. It receives one byte at a time, each marked by a valid strobe, and a stop strobe that marks the end of a write transaction. A leading control byte picks how the bytes that follow are read. They are either display data written into a page-organised frame memory, or command opcodes that move the column and page pointers and set the display flags.

The frame memory itself is outside the block. The decoder drives a single registered write port into it, with the address formed as column plus page times the row length. The display flags are the mirror, entire-display-on, inverse and enable flags. A sticky redraw flag tells the scan-out side that the memory has changed. Opcodes that take one parameter byte cause that byte to be swallowed. Opcodes outside the supported set raise a one-cycle unknown-command pulse.

Top module: `oled_byte_decoder`

## Requirements
- R1: After reset, all four display flags, the redraw flag, the error pulses and the write strobe are 0, both pointers are 0, and the block is waiting for a control byte.
- R2: While waiting for a control byte, 0x80 selects command mode and 0x40 selects data mode. Any other byte raises `ctrl_err` for one cycle, and the block keeps waiting for a control byte.
- R3: In data mode, a byte with column pointer below 132 produces a one-cycle `mem_we` with `mem_addr` = column + page*132 and `mem_wdata` equal to the byte. The column pointer then advances by one.
- R4: In data mode, a byte arriving with column pointer of 132 or more is dropped: no write occurs and the pointer does not move.
- R5: Data mode persists over any number of bytes until `xfer_stop`, after which the next byte is again read as a control byte.
- R6: A single executed command byte returns the block to waiting for a control byte.
- R7: Opcodes 0x00–0x0F replace column bits [3:0] with opcode bits [3:0]. Opcodes 0x10–0x20 replace column bits [7:4] with opcode bits [3:0].
- R8: Opcodes 0xB0–0xBF set the page pointer to opcode bits [2:0].
- R9: Opcode bit 0 gives the new flag value. 0xA0/0xA1 write mirror, 0xA4/0xA5 write entire-on, 0xA6/0xA7 write inverse, and 0xAE/0xAF write enable. The flags change only on such opcodes.
- R10: Opcodes 0x81, 0xA8, 0xAD, 0xD3, 0xD5, 0xD8, 0xD9, 0xDA and 0xDB arm a skip. The next byte received in command mode is then discarded without effect. Command mode stays selected after that byte, so the byte after it executes as a command.
- R11: Opcodes 0x40–0x7F, 0xC0–0xC8 and 0xE3 are accepted with no change of state and no error pulse.
- R12: Every other opcode raises `unknown_cmd` for one cycle and changes no pointer or flag.
- R13: `redraw` is set by every memory write and cleared by `redraw_ack`. A write in the same cycle as the acknowledge leaves it set.
- R14: A byte strobed in the same cycle as `xfer_stop` is discarded, and the block returns to waiting for a control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | A received byte is present this cycle |
| byte_data | input | 8 | Received byte |
| xfer_stop | input | 1 | End of the write transaction |
| redraw_ack | input | 1 | Scan-out side has consumed the frame |
| mem_we | output | 1 | Frame memory write strobe |
| mem_addr | output | 11 | Frame memory write address |
| mem_wdata | output | 8 | Frame memory write data |
| redraw | output | 1 | Sticky frame-changed flag |
| disp_mirror | output | 1 | Horizontal mirror flag |
| disp_all_on | output | 1 | Entire-display-on flag |
| disp_inverse | output | 1 | Inverse video flag |
| disp_enable | output | 1 | Display enable flag |
| ctrl_err | output | 1 | One-cycle pulse on a bad control byte |
| unknown_cmd | output | 1 | One-cycle pulse on an unsupported opcode |

## Verification
Every result is registered once, so each result appears one clock edge after the byte or strobe that causes it. This holds for the write strobe, address and data, the flags, both error pulses and the redraw flag. The bench drives each input on a falling edge and holds it for one full cycle. It samples at the next falling edge, the one just after the rising edge that consumed the input, which is the only cycle in which the single-cycle pulses are visible. Pointer changes have no port of their own. They are observed one data byte later through the address of the next write.

// File: rtl/oled_dec_pkg.sv
package oled_dec_pkg;

    localparam logic [7:0] CTRL_CMD  = 8'h80;
    localparam logic [7:0] CTRL_DATA = 8'h40;

    typedef enum logic [1:0] {
        MODE_IDLE,
        MODE_DATA,
        MODE_CMD
    } mode_e;

    typedef enum logic [2:0] {
        OP_COL_LO,
        OP_COL_HI,
        OP_PAGE,
        OP_FLAG,
        OP_PARAM,
        OP_NOP,
        OP_BAD
    } op_kind_e;

    typedef enum logic [1:0] {
        FL_MIRROR,
        FL_ALLON,
        FL_INVERSE,
        FL_ENABLE
    } flag_sel_e;

    typedef struct packed {
        op_kind_e  kind;
        flag_sel_e fsel;
        logic      fval;
        logic [3:0] nib;
    } op_dec_t;

    function automatic op_dec_t classify(input logic [7:0] b);
        op_dec_t d;
        d.kind = OP_BAD;
        d.fsel = FL_MIRROR;
        d.fval = b[0];
        d.nib  = b[3:0];
        if (b <= 8'h0F)                      d.kind = OP_COL_LO;
        else if (b <= 8'h20)                 d.kind = OP_COL_HI;
        else if (b >= 8'h40 && b <= 8'h7F)   d.kind = OP_NOP;
        else if (b >= 8'hB0 && b <= 8'hBF)   d.kind = OP_PAGE;
        else if (b >= 8'hC0 && b <= 8'hC8)   d.kind = OP_NOP;
        else begin
            case (b)
                8'hA0, 8'hA1: begin d.kind = OP_FLAG; d.fsel = FL_MIRROR;  end
                8'hA4, 8'hA5: begin d.kind = OP_FLAG; d.fsel = FL_ALLON;   end
                8'hA6, 8'hA7: begin d.kind = OP_FLAG; d.fsel = FL_INVERSE; end
                8'hAE, 8'hAF: begin d.kind = OP_FLAG; d.fsel = FL_ENABLE;  end
                8'h81, 8'hA8, 8'hAD, 8'hD3, 8'hD5,
                8'hD8, 8'hD9, 8'hDA, 8'hDB:  d.kind = OP_PARAM;
                8'hE3:                       d.kind = OP_NOP;
                default:                     d.kind = OP_BAD;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/oled_cmd_decode.sv
module oled_cmd_decode
    import oled_dec_pkg::*;
(
    input  logic [7:0] opcode,
    output op_dec_t    dec
);
    always_comb dec = classify(opcode);
endmodule

// File: rtl/oled_mode_ctrl.sv
module oled_mode_ctrl
    import oled_dec_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       byte_vld,
    input  logic [7:0] byte_data,
    input  logic       xfer_stop,
    input  logic       is_param,
    output logic       data_stb,
    output logic       cmd_stb,
    output logic       ctrl_err
);
    mode_e mode_q;
    logic  skip_q;

    assign data_stb = byte_vld && !xfer_stop && (mode_q == MODE_DATA);
    assign cmd_stb  = byte_vld && !xfer_stop && (mode_q == MODE_CMD) && !skip_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MODE_IDLE;
            skip_q   <= 1'b0;
            ctrl_err <= 1'b0;
        end else begin
            ctrl_err <= 1'b0;
            if (xfer_stop) begin
                mode_q <= MODE_IDLE;
            end else if (byte_vld) begin
                unique case (mode_q)
                    MODE_IDLE: begin
                        if (byte_data == CTRL_CMD)       mode_q <= MODE_CMD;
                        else if (byte_data == CTRL_DATA) mode_q <= MODE_DATA;
                        else                             ctrl_err <= 1'b1;
                    end
                    MODE_DATA: mode_q <= MODE_DATA;
                    MODE_CMD: begin
                        if (skip_q) begin
                            skip_q <= 1'b0;
                        end else begin
                            mode_q <= MODE_IDLE;
                            if (is_param) skip_q <= 1'b1;
                        end
                    end
                    default: mode_q <= MODE_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/oled_addr_track.sv
module oled_addr_track
    import oled_dec_pkg::*;
#(
    parameter int NUM_PAGES = 8,
    parameter int NUM_COLS  = 132,
    localparam int PAGE_W   = $clog2(NUM_PAGES),
    localparam int ADDR_W   = $clog2(NUM_PAGES * NUM_COLS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              data_stb,
    input  logic              cmd_stb,
    input  op_dec_t           dec,
    input  logic [7:0]        byte_data,
    input  logic              redraw_ack,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              redraw
);
    localparam logic [7:0]        COL_LIMIT = 8'(NUM_COLS);
    localparam logic [ADDR_W-1:0] ROW_LEN   = ADDR_W'(NUM_COLS);

    logic [7:0]        col_q;
    logic [PAGE_W-1:0] page_q;
    logic              in_range;

    assign in_range = col_q < COL_LIMIT;

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q     <= '0;
            page_q    <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            redraw    <= 1'b0;
        end else begin
            mem_we <= 1'b0;
            if (redraw_ack) redraw <= 1'b0;
            if (data_stb && in_range) begin
                mem_we    <= 1'b1;
                mem_addr  <= ADDR_W'(page_q) * ROW_LEN + ADDR_W'(col_q);
                mem_wdata <= byte_data;
                col_q     <= col_q + 8'd1;
                redraw    <= 1'b1;
            end
            if (cmd_stb) begin
                case (dec.kind)
                    OP_COL_LO: col_q[3:0] <= dec.nib;
                    OP_COL_HI: col_q[7:4] <= dec.nib;
                    OP_PAGE:   page_q     <= dec.nib[PAGE_W-1:0];
                    default:   ;
                endcase
            end
        end
    end
endmodule

// File: rtl/oled_flag_regs.sv
module oled_flag_regs
    import oled_dec_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cmd_stb,
    input  op_dec_t dec,
    output logic    disp_mirror,
    output logic    disp_all_on,
    output logic    disp_inverse,
    output logic    disp_enable,
    output logic    unknown_cmd
);
    always_ff @(posedge clk) begin
        if (rst) begin
            disp_mirror  <= 1'b0;
            disp_all_on  <= 1'b0;
            disp_inverse <= 1'b0;
            disp_enable  <= 1'b0;
            unknown_cmd  <= 1'b0;
        end else begin
            unknown_cmd <= 1'b0;
            if (cmd_stb) begin
                if (dec.kind == OP_FLAG) begin
                    unique case (dec.fsel)
                        FL_MIRROR:  disp_mirror  <= dec.fval;
                        FL_ALLON:   disp_all_on  <= dec.fval;
                        FL_INVERSE: disp_inverse <= dec.fval;
                        FL_ENABLE:  disp_enable  <= dec.fval;
                        default:    ;
                    endcase
                end else if (dec.kind == OP_BAD) begin
                    unknown_cmd <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/oled_byte_decoder.sv
module oled_byte_decoder
    import oled_dec_pkg::*;
#(
    parameter int NUM_PAGES = 8,
    parameter int NUM_COLS  = 132,
    localparam int ADDR_W   = $clog2(NUM_PAGES * NUM_COLS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_vld,
    input  logic [7:0]        byte_data,
    input  logic              xfer_stop,
    input  logic              redraw_ack,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              redraw,
    output logic              disp_mirror,
    output logic              disp_all_on,
    output logic              disp_inverse,
    output logic              disp_enable,
    output logic              ctrl_err,
    output logic              unknown_cmd
);
    op_dec_t dec;
    logic    data_stb;
    logic    cmd_stb;

    oled_cmd_decode u_dec (
        .opcode (byte_data),
        .dec    (dec)
    );

    oled_mode_ctrl u_mode (
        .clk       (clk),
        .rst       (rst),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .xfer_stop (xfer_stop),
        .is_param  (dec.kind == OP_PARAM),
        .data_stb  (data_stb),
        .cmd_stb   (cmd_stb),
        .ctrl_err  (ctrl_err)
    );

    oled_addr_track #(
        .NUM_PAGES (NUM_PAGES),
        .NUM_COLS  (NUM_COLS)
    ) u_addr (
        .clk        (clk),
        .rst        (rst),
        .data_stb   (data_stb),
        .cmd_stb    (cmd_stb),
        .dec        (dec),
        .byte_data  (byte_data),
        .redraw_ack (redraw_ack),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .redraw     (redraw)
    );

    oled_flag_regs u_flags (
        .clk          (clk),
        .rst          (rst),
        .cmd_stb      (cmd_stb),
        .dec          (dec),
        .disp_mirror  (disp_mirror),
        .disp_all_on  (disp_all_on),
        .disp_inverse (disp_inverse),
        .disp_enable  (disp_enable),
        .unknown_cmd  (unknown_cmd)
    );
endmodule

// File: rtl/oled_byte_decoder_chk.sv
module oled_byte_decoder_chk #(
    parameter int MEM_DEPTH = 1056,
    parameter int ADDR_W    = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              byte_vld,
    input logic              xfer_stop,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              redraw,
    input logic              disp_mirror,
    input logic              disp_all_on,
    input logic              disp_inverse,
    input logic              disp_enable,
    input logic              ctrl_err,
    input logic              unknown_cmd
);
    a_r3_addr_in_memory: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (32'(mem_addr) < MEM_DEPTH));

    a_r3_write_from_byte: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ($past(byte_vld) && !$past(xfer_stop)));

    a_r2_err_from_byte: assert property (@(posedge clk) disable iff (rst)
        ctrl_err |-> ($past(byte_vld) && !$past(xfer_stop)));

    a_r12_unknown_from_byte: assert property (@(posedge clk) disable iff (rst)
        unknown_cmd |-> ($past(byte_vld) && !$past(xfer_stop)));

    a_r9_flags_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(byte_vld) |-> $stable({disp_mirror, disp_all_on, disp_inverse, disp_enable}));

    a_r13_write_sets_redraw: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> redraw);

    a_r2_one_outcome: assert property (@(posedge clk) disable iff (rst)
        $countones({mem_we, ctrl_err, unknown_cmd}) <= 1);
endmodule

bind oled_byte_decoder oled_byte_decoder_chk #(
    .MEM_DEPTH (NUM_PAGES * NUM_COLS),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .byte_vld     (byte_vld),
    .xfer_stop    (xfer_stop),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .redraw       (redraw),
    .disp_mirror  (disp_mirror),
    .disp_all_on  (disp_all_on),
    .disp_inverse (disp_inverse),
    .disp_enable  (disp_enable),
    .ctrl_err     (ctrl_err),
    .unknown_cmd  (unknown_cmd)
);

// File: tb/oled_byte_decoder_tb.sv
module oled_byte_decoder_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic        xfer_stop = 1'b0;
    logic        redraw_ack = 1'b0;
    logic        mem_we;
    logic [10:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        redraw;
    logic        disp_mirror, disp_all_on, disp_inverse, disp_enable;
    logic        ctrl_err, unknown_cmd;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // bench model
    int m_col = 0;
    int m_page = 0;
    bit m_flags[4];

    always #2 clk = ~clk;

    oled_byte_decoder u_dut (
        .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_data(byte_data),
        .xfer_stop(xfer_stop), .redraw_ack(redraw_ack),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .redraw(redraw),
        .disp_mirror(disp_mirror), .disp_all_on(disp_all_on),
        .disp_inverse(disp_inverse), .disp_enable(disp_enable),
        .ctrl_err(ctrl_err), .unknown_cmd(unknown_cmd)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        byte_vld = 1'b1;
        byte_data = b;
        @(negedge clk);
        byte_vld = 1'b0;
    endtask

    task automatic stop();
        @(negedge clk);
        xfer_stop = 1'b1;
        @(negedge clk);
        xfer_stop = 1'b0;
    endtask

    task automatic check_flags(input string req);
        check(req, int'({disp_mirror, disp_all_on, disp_inverse, disp_enable}),
              int'({m_flags[0], m_flags[1], m_flags[2], m_flags[3]}));
    endtask

    // data byte with expected write computed from the model
    task automatic data_byte(input logic [7:0] b, input string req);
        send(b);
        if (m_col < 132) begin
            check(req, int'(mem_we), 1);
            check(req, int'(mem_addr), m_page * 132 + m_col);
            check(req, int'(mem_wdata), int'(b));
            m_col++;
        end else begin
            check(req, int'(mem_we), 0);
        end
    endtask

    function automatic bit takes_param(input int op);
        return op == 'h81 || op == 'hA8 || op == 'hAD || op == 'hD3 || op == 'hD5 ||
               (op >= 'hD8 && op <= 'hDB);
    endfunction

    function automatic bit is_unknown(input int op);
        if (op < 'h21) return 0;
        if (op >= 'h40 && op < 'h80) return 0;
        if (op / 16 == 'hB) return 0;
        if (op >= 'hC0 && op <= 'hC8) return 0;
        if (op == 'hE3 || takes_param(op)) return 0;
        if (op / 16 == 'hA && (op % 16 < 2 || (op % 16 >= 4 && op % 16 < 8) || op % 16 >= 14))
            return 0;
        return 1;
    endfunction

    task automatic model_cmd(input int op);
        if (op < 16) m_col = (m_col / 16) * 16 + op;
        else if (op <= 'h20) m_col = (op % 16) * 16 + m_col % 16;
        else if (op / 16 == 'hB) m_page = op % 8;
        else if (op / 16 == 'hA) begin
            case (op / 2)
                'h50: m_flags[0] = op[0];
                'h52: m_flags[1] = op[0];
                'h53: m_flags[2] = op[0];
                'h57: m_flags[3] = op[0];
                default: ;
            endcase
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) m_flags[i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 flags", int'({disp_mirror, disp_all_on, disp_inverse, disp_enable}), 0);
        check("R1 pulses", int'({mem_we, ctrl_err, unknown_cmd, redraw}), 0);
        send(8'h40);
        data_byte(8'h11, "R1 pointers zero");
        stop();

        // R2 control bytes
        send(8'h55);
        check("R2 bad control err", int'(ctrl_err), 1);
        @(negedge clk);
        check("R2 err one cycle", int'(ctrl_err), 0);
        send(8'h3C);
        check("R2 still idle", int'(ctrl_err), 1);
        check("R2 no write", int'(mem_we), 0);

        // exhaustive opcode sweep: R7 R8 R9 R10 R11 R12
        for (int op = 0; op < 256; op++) begin
            send(8'h80);
            check("R2 cmd select no err", int'(ctrl_err), 0);
            send(8'(op));
            model_cmd(op);
            check(is_unknown(op) ? "R12 unknown pulse" : "R11 accepted op",
                  int'(unknown_cmd), int'(is_unknown(op)));
            check_flags("R9 flags");
            if (takes_param(op)) begin
                send(8'h80);
                send(8'hFF);
                check("R10 param discarded", int'(unknown_cmd), 0);
            end
            stop();
            send(8'h40);
            data_byte(8'(op ^ 8'h5A), "R7 R8 write address");
            stop();
        end

        // R5 multi-byte burst with pointer setup
        send(8'h80); send(8'hB2); m_page = 2;
        send(8'h80); send(8'h05);
        send(8'h80); send(8'h10); m_col = 5;
        send(8'h40);
        for (int i = 0; i < 5; i++) data_byte(8'(8'hC0 + i), "R5 burst");
        stop();
        send(8'h40);
        check("R5 stop ends data", int'(ctrl_err), 0);
        stop();
        send(8'h99);
        check("R5 after stop control", int'(ctrl_err), 1);

        // R4 end of row
        send(8'h80); send(8'h18);
        send(8'h80); send(8'h03); m_col = 131;
        send(8'h40);
        data_byte(8'h77, "R4 last column");
        data_byte(8'h78, "R4 dropped");
        check("R4 still dropped", int'(mem_we), 0);
        stop();

        // R6 one command then idle
        send(8'h80); send(8'hA6); m_flags[2] = 0;
        send(8'hA7);
        check("R6 second byte is control", int'(ctrl_err), 1);
        check_flags("R6 flags unchanged");

        // R10 command mode kept after parameter
        send(8'h80); send(8'h81);
        send(8'h80); send(8'hA7);
        check_flags("R10 param byte no effect");
        send(8'hA7); m_flags[2] = 1;
        check("R10 next byte is command", int'(ctrl_err), 0);
        check_flags("R10 command executed");
        stop();

        // R13 redraw
        @(negedge clk); redraw_ack = 1'b1;
        @(negedge clk); redraw_ack = 1'b0;
        check("R13 ack clears", int'(redraw), 0);
        send(8'h80); send(8'h00);
        send(8'h80); send(8'h10); m_col = 0;
        send(8'h80); send(8'hB0); m_page = 0;
        send(8'h40);
        data_byte(8'h21, "R13 write");
        check("R13 set by write", int'(redraw), 1);
        @(negedge clk);
        byte_vld = 1'b1; byte_data = 8'h22; redraw_ack = 1'b1;
        @(negedge clk);
        byte_vld = 1'b0; redraw_ack = 1'b0;
        check("R13 write wins ack", int'(redraw), 1);
        check("R3 write with ack", int'(mem_addr), 1);
        m_col = 2;

        // R14 byte with stop
        @(negedge clk);
        byte_vld = 1'b1; byte_data = 8'h33; xfer_stop = 1'b1;
        @(negedge clk);
        byte_vld = 1'b0; xfer_stop = 1'b0;
        check("R14 byte discarded", int'(mem_we), 0);
        send(8'h33);
        check("R14 back to idle", int'(ctrl_err), 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule